// File: doc/BRIEF.md
# XAUI Link Fault Column Generator

This block sits on the receive side of a four-lane XAUI path, after code-group alignment, deskew and 8b/10b decoding. Each clock it takes one column of four decoded bytes with their control flags, along with per-lane health reports: signal present and comma lock for each lane, and one flag saying the lanes are deskewed. It produces a corrected column stream for the aggregated 32-bit interface.

While the XAUI function is enabled and any lane is unhealthy, every output column becomes the local-fault sequence ordered set. A fault sequence that arrives from the far end is forwarded unchanged. A separate flag marks each output column that is a sequence ordered set. While the XAUI function is disabled, columns pass straight through and the health inputs are ignored. All inputs are registered once before they are evaluated, and the output is registered, so every result appears exactly two clocks after its inputs.

Top module: `xfl_fault_gen`

## Requirements
- R1: While reset is asserted, tx_data, tx_ctrl and seq_flag are all zero.
- R2: While xaui_en is 0, tx_data and tx_ctrl equal rx_data and rx_ctrl from two clocks earlier, and seq_flag is 0. The health inputs have no effect.
- R3: With xaui_en set, if any bit of sig_det is 0, then two clocks later the output is the local-fault column: tx_data = 32'h0100009C and tx_ctrl = 4'b0001. Lane i occupies bits [8i+7:8i]. Lane 0 carries K28.4 (0x9C) with its K flag set, lanes 1 and 2 carry D0.0, and lane 3 carries D1.0. In this case seq_flag is 1.
- R4: With xaui_en set, if any bit of comma_ok is 0, the local-fault column with seq_flag = 1 appears two clocks later.
- R5: With xaui_en set, if deskew_done is 0, the local-fault column with seq_flag = 1 appears two clocks later.
- R6: With xaui_en set and all health inputs good, the received column is forwarded unchanged two clocks later.
- R7: With xaui_en set and health good, a received remote-fault column (32'h0200009C, ctrl 4'b0001) or local-fault column is forwarded unchanged, with seq_flag = 1.
- R8: With xaui_en set and health good, seq_flag is 1 exactly when the received lane 0 byte is 0x9C and rx_ctrl equals 4'b0001. A column with 0x9C on lane 0 and any other lane flagged as control gives seq_flag = 0.
- R9: A single clock of good health inputs after a fault is enough to make the matching output column, two clocks later, a forwarded column rather than a fault column.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Column clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| xaui_en | input | 1 | Enables fault handling and sequence handling |
| sig_det | input | 4 | Per-lane signal present |
| comma_ok | input | 4 | Per-lane comma lock |
| deskew_done | input | 1 | All lanes deskewed |
| rx_data | input | 32 | Received column, lane i at bits [8i+7:8i] |
| rx_ctrl | input | 4 | Received K flags, one per lane |
| tx_data | output | 32 | Corrected column |
| tx_ctrl | output | 4 | Corrected K flags |
| seq_flag | output | 1 | Output column is a sequence ordered set |

## Verification
Every result of the block, whether a fault column, a forwarded column or the sequence flag, is due exactly two clocks after the inputs that cause it: one register captures the inputs and a second holds the output. The bench keeps a two-deep history of expected columns. Each one is computed from the requirement rules at the time its inputs are driven, and it is compared one clock edge plus a small delay after the second following edge. The recovery case checks the column that follows a single good health cycle, which shows that no extra filtering delay exists.

// File: rtl/xfl_pkg.sv
package xfl_pkg;
    // Control code that opens a sequence ordered set (K28.4)
    localparam logic [7:0] SEQ_K_CODE  = 8'h9C;
    // Lane 3 payload of a local-fault sequence (D1.0)
    localparam logic [7:0] LOCAL_FAULT = 8'h01;
    // Filler byte on middle lanes (D0.0)
    localparam logic [7:0] SEQ_FILL    = 8'h00;
endpackage

// File: rtl/xfl_health.sv
module xfl_health #(
    parameter int NUM_LANES = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 xaui_en,
    input  logic [NUM_LANES-1:0] sig_det,
    input  logic [NUM_LANES-1:0] comma_ok,
    input  logic                 deskew_done,
    output logic                 en_q,
    output logic                 fault
);
    typedef struct packed {
        logic                 en;
        logic [NUM_LANES-1:0] sig;
        logic [NUM_LANES-1:0] comma;
        logic                 desk;
    } hstate_t;

    hstate_t st_d, st_q;

    always_comb begin
        st_d       = st_q;
        st_d.en    = xaui_en;
        st_d.sig   = sig_det;
        st_d.comma = comma_ok;
        st_d.desk  = deskew_done;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign en_q  = st_q.en;
    // Any lane without signal, any lane without comma lock, or lanes not aligned
    assign fault = !(&st_q.sig) || !(&st_q.comma) || !st_q.desk;
endmodule

// File: rtl/xfl_seq_match.sv
module xfl_seq_match #(
    parameter int NUM_LANES = 4,
    localparam int DW = 8 * NUM_LANES
) (
    input  logic [DW-1:0]        col_data,
    input  logic [NUM_LANES-1:0] col_ctrl,
    output logic                 is_seq
);
    import xfl_pkg::*;
    localparam logic [NUM_LANES-1:0] LANE0_ONLY = NUM_LANES'(1);

    assign is_seq = (col_data[7:0] == SEQ_K_CODE) && (col_ctrl == LANE0_ONLY);
endmodule

// File: rtl/xfl_fault_gen.sv
module xfl_fault_gen #(
    parameter int NUM_LANES = 4,
    localparam int DW = 8 * NUM_LANES
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 xaui_en,
    input  logic [NUM_LANES-1:0] sig_det,
    input  logic [NUM_LANES-1:0] comma_ok,
    input  logic                 deskew_done,
    input  logic [DW-1:0]        rx_data,
    input  logic [NUM_LANES-1:0] rx_ctrl,
    output logic [DW-1:0]        tx_data,
    output logic [NUM_LANES-1:0] tx_ctrl,
    output logic                 seq_flag
);
    import xfl_pkg::*;

    typedef struct packed {
        logic [DW-1:0]        cap_data;
        logic [NUM_LANES-1:0] cap_ctrl;
        logic [DW-1:0]        out_data;
        logic [NUM_LANES-1:0] out_ctrl;
        logic                 out_seq;
    } pstate_t;

    pstate_t st_d, st_q;
    logic en_q, fault, seq_hit;
    logic [DW-1:0]        lf_data;
    logic [NUM_LANES-1:0] lf_ctrl;

    xfl_health #(.NUM_LANES(NUM_LANES)) u_health (
        .clk(clk), .rst_n(rst_n), .xaui_en(xaui_en), .sig_det(sig_det),
        .comma_ok(comma_ok), .deskew_done(deskew_done),
        .en_q(en_q), .fault(fault)
    );

    xfl_seq_match #(.NUM_LANES(NUM_LANES)) u_match (
        .col_data(st_q.cap_data), .col_ctrl(st_q.cap_ctrl), .is_seq(seq_hit)
    );

    // Local-fault column, built lane by lane
    for (genvar i = 0; i < NUM_LANES; i++) begin : g_lf
        if (i == 0) begin : g_head
            assign lf_data[8*i +: 8] = SEQ_K_CODE;
            assign lf_ctrl[i]        = 1'b1;
        end else if (i == NUM_LANES - 1) begin : g_tail
            assign lf_data[8*i +: 8] = LOCAL_FAULT;
            assign lf_ctrl[i]        = 1'b0;
        end else begin : g_mid
            assign lf_data[8*i +: 8] = SEQ_FILL;
            assign lf_ctrl[i]        = 1'b0;
        end
    end

    always_comb begin
        st_d          = st_q;
        st_d.cap_data = rx_data;
        st_d.cap_ctrl = rx_ctrl;
        if (en_q && fault) begin
            st_d.out_data = lf_data;
            st_d.out_ctrl = lf_ctrl;
            st_d.out_seq  = 1'b1;
        end else begin
            st_d.out_data = st_q.cap_data;
            st_d.out_ctrl = st_q.cap_ctrl;
            st_d.out_seq  = en_q && seq_hit;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign tx_data  = st_q.out_data;
    assign tx_ctrl  = st_q.out_ctrl;
    assign seq_flag = st_q.out_seq;
endmodule

// File: rtl/xfl_fault_gen_chk.sv
module xfl_fault_gen_chk #(
    parameter int NUM_LANES = 4,
    localparam int DW = 8 * NUM_LANES
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 xaui_en,
    input logic [NUM_LANES-1:0] sig_det,
    input logic [NUM_LANES-1:0] comma_ok,
    input logic                 deskew_done,
    input logic [DW-1:0]        rx_data,
    input logic [NUM_LANES-1:0] rx_ctrl,
    input logic [DW-1:0]        tx_data,
    input logic [NUM_LANES-1:0] tx_ctrl,
    input logic                 seq_flag
);
    logic [1:0]           age;
    logic                 warm;
    logic [DW-1:0]        exp_lf;
    logic [NUM_LANES-1:0] exp_lf_k;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)          age <= '0;
        else if (age != 2'd3) age <= age + 2'd1;
    end
    assign warm = (age >= 2'd2);

    always_comb begin
        exp_lf   = '0;
        exp_lf_k = '0;
        exp_lf[7:0] = 8'h9C;
        exp_lf[DW-8 +: 8] = 8'h01;
        exp_lf_k[0] = 1'b1;
    end

    // R1
    reset_zero_chk: assert property (@(posedge clk)
        !rst_n |-> (tx_data == '0 && tx_ctrl == '0 && !seq_flag));

    // R2
    bypass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (warm && $past(!xaui_en, 2)) |->
        (tx_data == $past(rx_data, 2) && tx_ctrl == $past(rx_ctrl, 2) && !seq_flag));

    // R3
    no_signal_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (warm && $past(xaui_en && !(&sig_det), 2)) |->
        (tx_data == exp_lf && tx_ctrl == exp_lf_k && seq_flag));

    // R4
    no_comma_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (warm && $past(xaui_en && !(&comma_ok), 2)) |->
        (tx_data == exp_lf && tx_ctrl == exp_lf_k && seq_flag));

    // R5
    no_deskew_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (warm && $past(xaui_en && !deskew_done, 2)) |->
        (tx_data == exp_lf && tx_ctrl == exp_lf_k && seq_flag));

    // R6
    healthy_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (warm && $past(xaui_en && (&sig_det) && (&comma_ok) && deskew_done, 2)) |->
        (tx_data == $past(rx_data, 2) && tx_ctrl == $past(rx_ctrl, 2)));

    // R8
    seq_shape_chk: assert property (@(posedge clk) disable iff (!rst_n)
        seq_flag |-> (tx_data[7:0] == 8'h9C && tx_ctrl == NUM_LANES'(1)));
endmodule

bind xfl_fault_gen xfl_fault_gen_chk #(.NUM_LANES(NUM_LANES)) u_chk (.*);

// File: tb/xfl_fault_gen_test.sv
module xfl_fault_gen_test;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        xaui_en;
    logic [3:0]  sig_det, comma_ok;
    logic        deskew_done;
    logic [31:0] rx_data;
    logic [3:0]  rx_ctrl;
    logic [31:0] tx_data;
    logic [3:0]  tx_ctrl;
    logic        seq_flag;

    int errors = 0;
    int checks = 0;

    logic [36:0] exp1, exp2;
    string       tag1, tag2;
    logic        v1 = 1'b0, v2 = 1'b0;

    always #5 clk = ~clk;

    xfl_fault_gen uut (
        .clk(clk), .rst_n(rst_n), .xaui_en(xaui_en), .sig_det(sig_det),
        .comma_ok(comma_ok), .deskew_done(deskew_done), .rx_data(rx_data),
        .rx_ctrl(rx_ctrl), .tx_data(tx_data), .tx_ctrl(tx_ctrl), .seq_flag(seq_flag)
    );

    // Expected {seq_flag, tx_ctrl, tx_data} from one column of inputs
    function automatic logic [36:0] expect_col(logic en, logic [3:0] s, logic [3:0] c,
                                               logic dk, logic [31:0] d, logic [3:0] k);
        if (!en) return {1'b0, k, d};
        if (s != 4'hF || c != 4'hF || !dk) return {1'b1, 4'b0001, 32'h0100009C};
        return {(d[7:0] == 8'h9C && k == 4'b0001), k, d};
    endfunction

    function automatic string auto_tag(logic en, logic [3:0] s, logic [3:0] c,
                                       logic dk, logic [31:0] d, logic [3:0] k);
        if (!en) return "R2";
        if (s != 4'hF) return "R3";
        if (c != 4'hF) return "R4";
        if (!dk) return "R5";
        if (d[7:0] == 8'h9C && k == 4'b0001) return "R7";
        if (d[7:0] == 8'h9C) return "R8";
        return "R6";
    endfunction

    task automatic check(logic [36:0] got, logic [36:0] want, string tag);
        checks++;
        if (got !== want) begin
            errors++;
            $display("FAIL %s: actual flag=%b ctrl=%b data=%h expected flag=%b ctrl=%b data=%h",
                     tag, got[36], got[35:32], got[31:0], want[36], want[35:32], want[31:0]);
        end
    endtask

    task automatic step(logic en, logic [3:0] s, logic [3:0] c, logic dk,
                        logic [31:0] d, logic [3:0] k, string tag);
        @(posedge clk);
        #1;
        if (v2) check({seq_flag, tx_ctrl, tx_data}, exp2, tag2);
        exp2 = exp1; tag2 = tag1; v2 = v1;
        exp1 = expect_col(en, s, c, dk, d, k);
        tag1 = (tag == "") ? auto_tag(en, s, c, dk, d, k) : tag;
        v1   = 1'b1;
        xaui_en = en; sig_det = s; comma_ok = c; deskew_done = dk;
        rx_data = d; rx_ctrl = k;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        rst_n = 1'b0; xaui_en = 1'b1; sig_det = 4'h0; comma_ok = 4'h0;
        deskew_done = 1'b0; rx_data = 32'hDEADBEEF; rx_ctrl = 4'hF;
        for (int i = 0; i < 3; i++) begin
            @(posedge clk); #1;
            // R1: outputs held at zero in reset
            check({seq_flag, tx_ctrl, tx_data}, 37'd0, "R1");
        end
        @(negedge clk);
        rst_n = 1'b1;

        // R2: disabled, bad health ignored
        step(1'b0, 4'h0, 4'h0, 1'b0, 32'h11223344, 4'b0000, "");
        step(1'b0, 4'h3, 4'hF, 1'b0, 32'h0100009C, 4'b0001, "R2");
        // R3 / R4 / R5: each health condition alone
        step(1'b1, 4'b1110, 4'hF, 1'b1, 32'hAABBCCDD, 4'b0000, "");
        step(1'b1, 4'hF, 4'b1011, 1'b1, 32'h55667788, 4'b0010, "");
        step(1'b1, 4'hF, 4'hF, 1'b0, 32'h99887766, 4'b0000, "");
        // R9: one good cycle after fault is forwarded
        step(1'b1, 4'hF, 4'hF, 1'b1, 32'h12345678, 4'b0000, "R9");
        // R6: healthy pass-through
        step(1'b1, 4'hF, 4'hF, 1'b1, 32'hFBFBFBFB, 4'b1111, "");
        // R7: remote and local fault columns from far end
        step(1'b1, 4'hF, 4'hF, 1'b1, 32'h0200009C, 4'b0001, "");
        step(1'b1, 4'hF, 4'hF, 1'b1, 32'h0100009C, 4'b0001, "R7");
        // R8: lane 0 K28.4 but another lane is control
        step(1'b1, 4'hF, 4'hF, 1'b1, 32'h0200009C, 4'b0101, "R8");
        step(1'b1, 4'hF, 4'hF, 1'b1, 32'h0000009C, 4'b0000, "R8");
        step(1'b1, 4'h7, 4'hF, 1'b1, 32'h0200009C, 4'b0001, "R3");
        step(1'b1, 4'hF, 4'hF, 1'b1, 32'h0200009C, 4'b0001, "R9");

        for (int n = 0; n < 3000; n++) begin
            logic en = ($urandom % 8) != 0;
            logic [3:0] s = (($urandom % 10) == 0) ? 4'($urandom) : 4'hF;
            logic [3:0] c = (($urandom % 10) == 0) ? 4'($urandom) : 4'hF;
            logic dk = ($urandom % 10) != 0;
            logic [31:0] d = $urandom;
            logic [3:0] k = (($urandom % 4) == 0) ? 4'($urandom) : 4'h0;
            if (($urandom % 5) == 0) begin
                d = {(($urandom % 2) != 0) ? 8'h02 : 8'h01, 16'h0000, 8'h9C};
                k = (($urandom % 4) == 0) ? 4'($urandom) : 4'b0001;
            end
            step(en, s, c, dk, d, k, "");
        end
        step(1'b0, 4'hF, 4'hF, 1'b1, 32'h0, 4'h0, "R2");
        step(1'b0, 4'hF, 4'hF, 1'b1, 32'h0, 4'h0, "R2");
        step(1'b0, 4'hF, 4'hF, 1'b1, 32'h0, 4'h0, "R2");

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule